// File: doc/BRIEF.md
# Wormhole Mesh Router Output Allocator

This block is the switch-allocation and forwarding stage of a five-port wormhole router in a mesh network. The five ports are local, north, east, south and west. Each input takes one flit per handshake into a small FIFO. A flit carries a head flag, a tail flag, a destination output index worked out upstream, and a data word. For each output, an allocator picks one input whose head flit targets that output. It then holds the output for that input until the packet's tail has been handed over, so the flits of different packets never interleave on a link.

Flits go from the head of an input FIFO straight onto the chosen output in the cycle of the grant. A flit accepted at one clock edge can leave at the next. The lock on an output drops in the same cycle that the tail's handshake completes. A packet from another input can therefore follow in the very next cycle, and the tail is never sent twice. A packet of a single flit has both flags set. It is granted and released together and leaves no lock behind. When several heads want a free output, a rotating priority picks the winner. Downstream flow control is a plain ready per output, and upstream flow control is a plain ready per input.

Top module: `wh_out_alloc`

## Requirements
- R1: After reset, every out_valid is low and every in_ready is high.
- R2: A flit accepted on input i with destination index o appears on output o with unchanged data, head and tail flags. When the output is free and ready, this happens in the cycle after acceptance. Output indices are 0 local, 1 north, 2 east, 3 south and 4 west.
- R3: Once a head without tail has been forwarded on an output, only flits from the same input appear on that output until that input's tail has been forwarded.
- R4: Every accepted flit is forwarded exactly once, and the flits of one input leave in the order they were accepted.
- R5: A tail handshake frees its output in that same cycle. A head waiting on another input for that output is forwarded in the next cycle.
- R6: Take a tail that enters on one input in cycle T0 and is forwarded in T1, while a single-flit packet for the same output enters another input in T1. The single flit is forwarded in T2, and the tail appears only once.
- R7: A single-flit packet (head and tail both 1) that is forwarded leaves its output unlocked.
- R8: When heads on several inputs compete for a free output, the winner is the first requesting input found by counting upward from the previous winner, wrapping at 4. After reset the previous winner is taken as input 4.
- R9: While an output shows valid with its ready low, nothing is taken from any input for it. Its valid stays high, and its data and flags stay unchanged, even if a higher-priority head arrives meanwhile.
- R10: Each input buffers two flits. in_ready falls only when two flits are held. A flit presented while in_ready is low is not taken, and in_ready returns in the cycle after a flit leaves that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit present, one bit per input |
| in_ready | output | 5 | Input FIFO has room, one bit per input |
| in_head | input | 5 | Head flag per input |
| in_tail | input | 5 | Tail flag per input |
| in_dst | input | 5x3 | Destination output index per input |
| in_data | input | 5x32 | Data word per input |
| out_valid | output | 5 | Flit presented, one bit per output |
| out_ready | input | 5 | Downstream accepts, one bit per output |
| out_head | output | 5 | Head flag per output |
| out_tail | output | 5 | Tail flag per output |
| out_data | output | 5x32 | Data word per output |

## Verification
The properties rely on the upstream side following these rules:
- An input keeps its valid and its flit fields steady until the handshake takes the flit.
- Each input sends its packets whole, with the head first, the tail last and the same destination on every flit.
- No input starts a new packet before its previous tail.

The stimulus keeps to these rules. A flit stays on the pins until its acceptance is seen, and a per-input generator finishes every packet it starts, even during the final drain. It picks only destinations other than the input's own index. Backpressure comes from random ready patterns on the outputs and is never applied on the input side.

// File: rtl/wh_alloc_pkg.sv
package wh_alloc_pkg;

    localparam int NUM_PORTS = 5;
    localparam int PORT_W    = $clog2(NUM_PORTS);
    localparam int DATA_W    = 32;

    typedef enum logic [PORT_W-1:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    typedef struct packed {
        logic              head;
        logic              tail;
        logic [PORT_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } flit_t;

endpackage

// File: rtl/wh_in_fifo.sv
module wh_in_fifo
    import wh_alloc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  flit_t din,
    output logic  full,
    input  logic  pop,
    output logic  q_valid,
    output flit_t q_flit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    flit_t            mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign q_valid = (cnt != '0);
    assign q_flit  = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && q_valid;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= ptr_inc(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] last,
    output logic                 gnt_any,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = last;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = int'(last) + k;
            if (c >= N) c = c - N;
            if (!gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(c);
            end
        end
    end
endmodule

// File: rtl/wh_out_lane.sv
module wh_out_lane
    import wh_alloc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] q_valid,
    input  logic [NUM_PORTS-1:0] q_head,
    input  logic [NUM_PORTS-1:0] q_tail,
    input  logic [NUM_PORTS-1:0] hit,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic                 fire,
    output logic [PORT_W-1:0]    sel,
    output logic                 lock,
    output logic [PORT_W-1:0]    owner
);
    logic [NUM_PORTS-1:0] req;
    logic                 gnt_any;
    logic [PORT_W-1:0]    gnt_idx, last_q, owner_q;
    logic                 lock_q;

    assign req = q_valid & q_head & hit;

    wh_rr_arb #(.N(NUM_PORTS)) u_arb (
        .req     (req),
        .last    (last_q),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        if (lock_q) begin
            sel       = owner_q;
            out_valid = q_valid[owner_q] && hit[owner_q];
        end else begin
            sel       = gnt_idx;
            out_valid = gnt_any;
        end
    end

    assign fire  = out_valid && out_ready;
    assign lock  = lock_q;
    assign owner = owner_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            owner_q <= '0;
            last_q  <= PORT_W'(NUM_PORTS - 1);
        end else if (lock_q) begin
            if (fire && q_tail[owner_q]) lock_q <= 1'b0;
        end else if (out_valid) begin
            last_q <= gnt_idx;
            if (!(fire && q_tail[gnt_idx])) begin
                lock_q  <= 1'b1;
                owner_q <= gnt_idx;
            end
        end
    end
endmodule

// File: rtl/wh_out_alloc.sv
module wh_out_alloc
    import wh_alloc_pkg::*;
#(
    parameter int FIFO_DEPTH = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PORTS-1:0]             in_valid,
    output logic [NUM_PORTS-1:0]             in_ready,
    input  logic [NUM_PORTS-1:0]             in_head,
    input  logic [NUM_PORTS-1:0]             in_tail,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0] in_dst,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] in_data,
    output logic [NUM_PORTS-1:0]             out_valid,
    input  logic [NUM_PORTS-1:0]             out_ready,
    output logic [NUM_PORTS-1:0]             out_head,
    output logic [NUM_PORTS-1:0]             out_tail,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] out_data
);
    localparam int NP = NUM_PORTS;
    localparam int PW = PORT_W;

    flit_t              q_flit [NP];
    logic [NP-1:0]      q_valid, q_head, q_tail;
    logic [NP-1:0]      fifo_full, fifo_pop;
    logic [NP-1:0]      lane_fire, lane_lock;
    logic [NP-1:0][PW-1:0] lane_sel, lane_owner;
    logic [NP-1:0]      lane_hit [NP];

    for (genvar i = 0; i < NP; i++) begin : g_in
        flit_t in_flit;
        assign in_flit = '{head: in_head[i], tail: in_tail[i],
                           dst: in_dst[i], data: in_data[i]};
        wh_in_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .push    (in_valid[i]),
            .din     (in_flit),
            .full    (fifo_full[i]),
            .pop     (fifo_pop[i]),
            .q_valid (q_valid[i]),
            .q_flit  (q_flit[i])
        );
        assign in_ready[i] = !fifo_full[i];
        assign q_head[i]   = q_flit[i].head;
        assign q_tail[i]   = q_flit[i].tail;
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        for (genvar i = 0; i < NP; i++) begin : g_hit
            assign lane_hit[o][i] = (q_flit[i].dst == PW'(o));
        end
        wh_out_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .q_valid   (q_valid),
            .q_head    (q_head),
            .q_tail    (q_tail),
            .hit       (lane_hit[o]),
            .out_ready (out_ready[o]),
            .out_valid (out_valid[o]),
            .fire      (lane_fire[o]),
            .sel       (lane_sel[o]),
            .lock      (lane_lock[o]),
            .owner     (lane_owner[o])
        );
        assign out_head[o] = q_flit[lane_sel[o]].head;
        assign out_tail[o] = q_flit[lane_sel[o]].tail;
        assign out_data[o] = q_flit[lane_sel[o]].data;
    end

    always_comb begin
        fifo_pop = '0;
        for (int o = 0; o < NP; o++) begin
            if (lane_fire[o]) fifo_pop[lane_sel[o]] = 1'b1;
        end
    end
endmodule

// File: rtl/wh_alloc_chk.sv
module wh_alloc_chk
    import wh_alloc_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_PORTS-1:0]             in_ready,
    input logic [NUM_PORTS-1:0]             out_valid,
    input logic [NUM_PORTS-1:0]             out_ready,
    input logic [NUM_PORTS-1:0]             out_head,
    input logic [NUM_PORTS-1:0]             out_tail,
    input logic [NUM_PORTS-1:0][DATA_W-1:0] out_data,
    input logic [NUM_PORTS-1:0]             pop,
    input logic [NUM_PORTS-1:0]             fire,
    input logic [NUM_PORTS-1:0]             lock,
    input logic [NUM_PORTS-1:0][PORT_W-1:0] owner
);
    // R1: reset leaves outputs idle and inputs open
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && in_ready == '1));

    // R4: each output handshake removes exactly one flit from one input
    a_r4_fire_matches_pop: assert property (@(posedge clk) disable iff (rst)
        $countones(fire) == $countones(pop));

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_o
        // R9: a stalled output holds its flit
        a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_data[o]) && $stable(out_head[o])
             && $stable(out_tail[o])));

        // R5: tail handshake frees the output
        a_r5_tail_unlocks: assert property (@(posedge clk) disable iff (rst)
            (fire[o] && out_tail[o]) |=> !lock[o]);

        // R7: single-flit packet leaves no lock
        a_r7_single_free: assert property (@(posedge clk) disable iff (rst)
            (fire[o] && out_head[o] && out_tail[o]) |=> !lock[o]);

        // R3: a locked output only drains its owner
        a_r3_owner_pops: assert property (@(posedge clk) disable iff (rst)
            (lock[o] && fire[o]) |-> pop[owner[o]]);

        // R3: lock and owner persist until the tail
        a_r3_lock_kept: assert property (@(posedge clk) disable iff (rst)
            (lock[o] && !(fire[o] && out_tail[o])) |=>
            (lock[o] && $stable(owner[o])));
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_i
        // R10: space returns the cycle after a flit leaves
        a_r10_room_after_pop: assert property (@(posedge clk) disable iff (rst)
            pop[i] |=> in_ready[i]);
    end
endmodule

bind wh_out_alloc wh_alloc_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_head  (out_head),
    .out_tail  (out_tail),
    .out_data  (out_data),
    .pop       (fifo_pop),
    .fire      (lane_fire),
    .lock      (lane_lock),
    .owner     (lane_owner)
);

// File: tb/wh_out_alloc_tb.sv
module wh_out_alloc_tb_top;
    import wh_alloc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = NUM_PORTS;
    localparam int PW = PORT_W;
    localparam int DW = DATA_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]         in_valid = '0, in_ready, in_head = '0, in_tail = '0;
    logic [NP-1:0][PW-1:0] in_dst = '0;
    logic [NP-1:0][DW-1:0] in_data = '0;
    logic [NP-1:0]         out_valid, out_ready = '1, out_head, out_tail;
    logic [NP-1:0][DW-1:0] out_data;

    typedef struct {
        int               cyc;
        int               src;
        logic [DW-1:0]    data;
        logic             tail;
    } ev_t;

    flit_t exp_q [NP][$];
    ev_t   log_q [NP][$];
    int    cyc = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    bit    busy [NP];
    int    own  [NP];

    wh_out_alloc dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_head(in_head),
        .in_tail(in_tail), .in_dst(in_dst), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_head(out_head),
        .out_tail(out_tail), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] mkdata(input int src, input int seq);
        return {PW'(src), (DW-PW)'(seq)};
    endfunction

    // monitor: scoreboard against per-input expected queues
    always @(negedge clk) begin
        if (rst) begin
            for (int o = 0; o < NP; o++) busy[o] = 0;
        end else begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    int   src;
                    ev_t  ev;
                    src = int'(out_data[o][DW-1 -: PW]);
                    ev.cyc = cyc; ev.src = src; ev.data = out_data[o]; ev.tail = out_tail[o];
                    log_q[o].push_back(ev);
                    if (src >= NP || exp_q[src].size() == 0) begin
                        chk(0, "R4 flit forwarded with none pending", 64'(out_data[o]), 0);
                    end else begin
                        flit_t e;
                        e = exp_q[src].pop_front();
                        chk(e.data == out_data[o] && e.head == out_head[o] &&
                            e.tail == out_tail[o] && int'(e.dst) == o,
                            "R2 forwarded flit content or route",
                            {o[3:0], out_head[o], out_tail[o], out_data[o]},
                            {e.dst[3:0], e.head, e.tail, e.data});
                    end
                    if (busy[o] && src != own[o])
                        chk(0, "R3 packet interleaved on locked output", src, own[o]);
                    if (out_head[o] && !out_tail[o]) begin
                        busy[o] = 1; own[o] = src;
                    end
                    if (out_tail[o]) busy[o] = 0;
                end
            end
        end
    end

    task automatic set_in(input int i, input int dst, input bit h, input bit t, input int seq);
        in_valid[i] = 1'b1;
        in_dst[i]   = PW'(dst);
        in_head[i]  = h;
        in_tail[i]  = t;
        in_data[i]  = mkdata(i, seq);
    endtask

    // one cycle: observe acceptance, then record it as expected output
    task automatic tick();
        logic [NP-1:0] acc;
        @(negedge clk);
        acc = in_valid & in_ready;
        @(posedge clk);
        #1;
        for (int i = 0; i < NP; i++) begin
            if (acc[i]) begin
                flit_t f;
                f.head = in_head[i]; f.tail = in_tail[i];
                f.dst = in_dst[i]; f.data = in_data[i];
                exp_q[i].push_back(f);
                in_valid[i] = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = '0;
        out_ready = '1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        for (int i = 0; i < NP; i++) begin
            exp_q[i].delete();
            log_q[i].delete();
        end
    endtask

    task automatic chk_log(input int o, input int k, input int src, input int c,
                           input string req);
        if (k >= log_q[o].size()) begin
            chk(0, req, 64'(log_q[o].size()), 64'(k + 1));
        end else begin
            chk(log_q[o][k].src == src && log_q[o][k].cyc == c, req,
                {32'(log_q[o][k].src), 32'(log_q[o][k].cyc)}, {32'(src), 32'(c)});
        end
    endtask

    task automatic clear_logs();
        for (int o = 0; o < NP; o++) log_q[o].delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog expired", 64'(cyc), 0);
        finish_sim();
    end

    initial begin
        int c0;
        int rem  [NP];
        int pdst [NP];
        int seq  [NP];

        // R1
        do_reset();
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid idle after reset", 64'(out_valid), 0);
        chk(in_ready == '1, "R1 in_ready high after reset", 64'(in_ready), 64'('1));
        @(posedge clk); #1;

        // R8: rotating priority on output 2 (east)
        clear_logs();
        c0 = cyc;
        set_in(1, 2, 1, 1, 1); set_in(3, 2, 1, 1, 2); set_in(4, 2, 1, 1, 3);
        tick(); repeat (4) tick();
        chk_log(2, 0, 1, c0 + 1, "R8 first winner after reset");
        chk_log(2, 1, 3, c0 + 2, "R8 second winner");
        chk_log(2, 2, 4, c0 + 3, "R8 third winner");
        clear_logs();
        c0 = cyc;
        set_in(0, 2, 1, 1, 4); set_in(3, 2, 1, 1, 5);
        tick(); repeat (3) tick();
        chk_log(2, 0, 0, c0 + 1, "R8 wrap past input 4");
        chk_log(2, 1, 3, c0 + 2, "R8 wrap second");
        clear_logs();
        c0 = cyc;
        set_in(1, 2, 1, 1, 6); set_in(4, 2, 1, 1, 7);
        tick(); repeat (3) tick();
        chk_log(2, 0, 4, c0 + 1, "R8 rotate past last winner 3");
        chk_log(2, 1, 1, c0 + 2, "R8 rotate second");

        // R6: tail at T0 on west, single flit on local at T1, both to north
        clear_logs();
        c0 = cyc;
        set_in(4, 1, 1, 0, 10); tick();
        set_in(4, 1, 0, 1, 11); tick();
        set_in(0, 1, 1, 1, 12); tick();
        repeat (4) tick();
        chk_log(1, 0, 4, c0 + 1, "R6 head forwarded");
        chk_log(1, 1, 4, c0 + 2, "R6 tail forwarded at T1");
        chk_log(1, 2, 0, c0 + 3, "R6 single flit forwarded at T2");
        chk(log_q[1].size() == 3, "R6 tail not replayed", 64'(log_q[1].size()), 3);

        // R3 + R5: 3-flit packet with a competitor waiting
        clear_logs();
        c0 = cyc;
        set_in(2, 3, 1, 0, 20); tick();
        set_in(2, 3, 0, 0, 21); set_in(1, 3, 1, 1, 22); tick();
        set_in(2, 3, 0, 1, 23); tick();
        repeat (4) tick();
        chk_log(3, 1, 2, c0 + 2, "R3 body stays with owner");
        chk_log(3, 2, 2, c0 + 3, "R3 tail stays with owner");
        chk_log(3, 3, 1, c0 + 4, "R5 waiting head follows tail at once");

        // R7: single flit leaves output free for a later head
        clear_logs();
        c0 = cyc;
        set_in(0, 4, 1, 1, 25); tick();
        set_in(3, 4, 1, 0, 26); tick();
        set_in(3, 4, 0, 1, 27); tick();
        repeat (3) tick();
        chk_log(4, 0, 0, c0 + 1, "R7 single flit sent");
        chk_log(4, 1, 3, c0 + 2, "R7 next head granted without lock");

        // R9: stall holds flit even against higher priority arrival
        do_reset();
        out_ready[1] = 1'b0;
        set_in(2, 1, 1, 1, 30); tick();
        set_in(0, 1, 1, 1, 31); tick();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid[1] && out_data[1] == mkdata(2, 30), "R9 stalled flit held",
                {31'(0), out_valid[1], out_data[1]}, {31'(0), 1'b1, mkdata(2, 30)});
            @(posedge clk); #1;
        end
        chk(log_q[1].size() == 0, "R9 nothing taken while stalled", 64'(log_q[1].size()), 0);
        out_ready[1] = 1'b1;
        c0 = cyc;
        repeat (4) tick();
        chk_log(1, 0, 2, c0, "R9 held flit goes first");
        chk_log(1, 1, 0, c0 + 1, "R9 later head second");

        // R10: two-entry buffer
        do_reset();
        out_ready[3] = 1'b0;
        set_in(1, 3, 1, 1, 40); tick();
        set_in(1, 3, 1, 1, 41); tick();
        set_in(1, 3, 1, 1, 42);
        @(negedge clk);
        chk(in_ready[1] == 1'b0, "R10 ready low with two held", 64'(in_ready[1]), 0);
        @(posedge clk); #1;
        tick(); tick();
        chk(exp_q[1].size() == 2, "R10 flit not taken while full", 64'(exp_q[1].size()), 2);
        out_ready[3] = 1'b1;
        repeat (6) tick();
        chk(log_q[3].size() == 3 && exp_q[1].size() == 0, "R10 all three delivered",
            64'(log_q[3].size()), 3);
        if (log_q[3].size() == 3)
            chk(log_q[3][2].data == mkdata(1, 42), "R4 order kept per input",
                64'(log_q[3][2].data), 64'(mkdata(1, 42)));

        // random traffic: R2, R3, R4 via scoreboard
        do_reset();
        for (int i = 0; i < NP; i++) begin rem[i] = 0; seq[i] = 100; pdst[i] = 0; end
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NP; i++) begin
                if (!in_valid[i]) begin
                    if (rem[i] > 0) begin
                        if ($urandom % 4 != 0) begin
                            rem[i]--;
                            set_in(i, pdst[i], 0, rem[i] == 0, seq[i]++);
                        end
                    end else if ($urandom % 3 == 0) begin
                        rem[i] = int'($urandom % 4);
                        pdst[i] = (i + 1 + int'($urandom % 4)) % NP;
                        set_in(i, pdst[i], 1, rem[i] == 0, seq[i]++);
                    end
                end
            end
            out_ready = NP'($urandom);
            tick();
        end
        out_ready = '1;
        for (int n = 0; n < 200; n++) begin
            for (int i = 0; i < NP; i++) begin
                if (!in_valid[i] && rem[i] > 0) begin
                    rem[i]--;
                    set_in(i, pdst[i], 0, rem[i] == 0, seq[i]++);
                end
            end
            tick();
        end
        for (int i = 0; i < NP; i++)
            chk(exp_q[i].size() == 0, "R4 every accepted flit delivered",
                64'(exp_q[i].size()), 0);

        finish_sim();
    end
endmodule